// File: doc/BRIEF.md
# Event Packet Serial Reporter

This block gathers power-management activity strobes into one sticky 8-bit packet and sends that packet on a single serial line to a companion device. Each event type has its own packet bit. A bit, once set, stays set until the next frame that carried it has finished. Repeats of one event between frames change nothing, while different events add together in the packet.

Frames go out in two cases. The first is periodic: the selected interval must have elapsed and the packet must be non-zero. The second is on demand: software writes the test bit. Interval lengths are built from a parameterised clock-ticks-per-millisecond count. A small register port lets software write the control byte, and read back the control byte or the packet.

Top module: `evt_pkt_reporter`

## Requirements
- R1: After reset `ser_out` is 1, the control readback (`reg_sel`=0) is 0x00 and the packet readback (`reg_sel`=1) is 0x00.
- R2: The packet bit map is as follows. Bit 7 is vertical sync (`ev_vsync`). Bit 6 is cache-miss activity. Bit 1 is an address-decode hit (`ev_addr_hit`). Bit 0 is a video/display access. Bits 5:2 always read 0. A strobe sampled at a clock edge is visible in the packet readback from that edge onward.
- R3: A set packet bit stays set until a frame completes. Repeating an event has no further effect. Distinct events accumulate in the packet.
- R4: Cache misses (`ev_miss`) set bit 6 only when control bit 3 (miss enable) is 1 and `ev_miss_ifetch` is 0. A write miss (`ev_miss_wr`=1) also needs nothing more. A read miss also needs control bit 4 (read enable) to be 1.
- R5: A video/display access (`ev_vid_acc`) sets bit 0 only when control bit 2 (video enable) is 1.
- R6: Control bits 1:0 select the interval. 00 means no periodic sends. 01, 10 and 11 select 1, 5 and 10 times `TICKS_PER_MS` cycles. With a non-zero packet, the frame's start bit appears that many cycles after the clock edge that wrote the control byte.
- R7: A packet of all zeros is never sent when the interval expires.
- R8: Writing a control byte with bit 7 set starts a frame at that same clock edge, provided the line is idle. Control bit 7 always reads back 0.
- R9: A frame is a low start bit, then the 8 packet bits LSB first, then a high stop bit. Each bit lasts `BIT_TICKS` cycles. The line idles high.
- R10: When a frame completes, the bits it carried are cleared. An event sampled at the completing edge is kept.
- R11: The frame content is captured at frame start. Events that arrive while the frame is shifting stay set after it completes, even when they hit a bit the frame carries.
- R12: The interval counter restarts when a frame completes and on every control write. The next periodic frame starts one interval after the completing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control byte |
| reg_sel | input | 1 | Register select: 0 selects control, 1 selects the packet (read only) |
| reg_wdata | input | 8 | Control write data |
| reg_rdata | output | 8 | Readback of the selected register |
| ev_vsync | input | 1 | Vertical sync event strobe |
| ev_miss | input | 1 | Level-1 cache miss strobe |
| ev_miss_wr | input | 1 | Miss qualifier: 1 for a write, 0 for a read |
| ev_miss_ifetch | input | 1 | Miss was caused by an instruction fetch |
| ev_addr_hit | input | 1 | Programmable address decode hit strobe |
| ev_vid_acc | input | 1 | Graphics memory or display register access strobe |
| ser_out | output | 1 | Serial packet line |

## Verification
The packet register is updated at the edge that samples a strobe. The bench therefore drives strobes at a falling edge and reads the packet at the next falling edge. A test-bit write puts the start bit on the line at the writing edge, so the line is already low at the falling edge that follows the write. A periodic frame starts exactly L cycles after the restarting edge. The bench counts falling edges from that restart and expects exactly L. For a frame that starts at edge S, each bit is sampled one and a half cycles into its bit period, and the completing edge is S + 10·`BIT_TICKS`. Strobes used to probe that edge are set up half a cycle before it.

// File: rtl/evrp_pkg.sv
package evrp_pkg;
  localparam int PKT_W      = 8;
  localparam int FRAME_BITS = 10;
  localparam int B_VSYNC    = 7;
  localparam int B_MISS     = 6;
  localparam int B_HIT      = 1;
  localparam int B_VID      = 0;

  typedef enum logic [1:0] {
    IV_OFF = 2'b00, IV_1MS = 2'b01, IV_5MS = 2'b10, IV_10MS = 2'b11
  } ival_e;

  // cycles in one interval for a given select code
  function automatic int unsigned interval_ticks(input logic [1:0] sel, input int unsigned tpm);
    case (ival_e'(sel))
      IV_1MS:  return tpm;
      IV_5MS:  return 5 * tpm;
      IV_10MS: return 10 * tpm;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/evrp_collector.sv
module evrp_collector
  import evrp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_vsync,
  input  logic             ev_miss,
  input  logic             ev_miss_wr,
  input  logic             ev_miss_ifetch,
  input  logic             ev_addr_hit,
  input  logic             ev_vid_acc,
  input  logic             vid_en,
  input  logic             miss_en,
  input  logic             rd_en,
  input  logic             start,
  input  logic             busy,
  input  logic             done,
  output logic [PKT_W-1:0] pkt
);
  logic [PKT_W-1:0] pkt_q, snap_q, fresh_q, set_vec, clr_mask;
  logic             miss_ok;

  assign miss_ok = ev_miss && !ev_miss_ifetch && miss_en && (ev_miss_wr || rd_en);

  always_comb begin
    set_vec          = '0;
    set_vec[B_VSYNC] = ev_vsync;
    set_vec[B_MISS]  = miss_ok;
    set_vec[B_HIT]   = ev_addr_hit;
    set_vec[B_VID]   = ev_vid_acc && vid_en;
  end

  assign clr_mask = done ? (snap_q & ~fresh_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_q   <= '0;
      snap_q  <= '0;
      fresh_q <= '0;
    end else begin
      pkt_q <= (pkt_q & ~clr_mask) | set_vec;
      if (start) begin
        snap_q  <= pkt_q;
        fresh_q <= '0;
      end else if (busy) begin
        fresh_q <= fresh_q | set_vec;
      end
    end
  end

  assign pkt = pkt_q;

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(done) |-> ((pkt_q & $past(pkt_q)) == $past(pkt_q)));
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_q[5:2] == 4'b0000);
endmodule

// File: rtl/evrp_timer.sv
module evrp_timer
  import evrp_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       restart,
  output logic       expire
);
  localparam int CW = $clog2(10 * TICKS_PER_MS + 1);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last   = CW'(interval_ticks(sel, TICKS_PER_MS) - 1);
  assign expire = (sel != 2'b00) && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (restart || expire || sel == 2'b00) cnt_q <= '0;
    else                                 cnt_q <= cnt_q + 1'b1;
  end

  // R6
  off_no_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b00) |-> !expire);
endmodule

// File: rtl/evrp_shifter.sv
module evrp_shifter
  import evrp_pkg::*;
#(
  parameter int unsigned BIT_TICKS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PKT_W-1:0] pkt_in,
  output logic             busy,
  output logic             done,
  output logic             ser_out
);
  localparam int TW = (BIT_TICKS > 1) ? $clog2(BIT_TICKS) : 1;
  logic [PKT_W:0] data_q;
  logic [3:0]     bit_q;
  logic [TW-1:0]  tick_q;
  logic           busy_q, ser_q;
  logic           bit_end;

  assign bit_end = (tick_q == TW'(BIT_TICKS - 1));
  assign done    = busy_q && bit_end && (bit_q == 4'(FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ser_q  <= 1'b1;
      data_q <= '1;
      bit_q  <= '0;
      tick_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      ser_q  <= 1'b0;
      data_q <= {1'b1, pkt_in};
      bit_q  <= '0;
      tick_q <= '0;
    end else if (busy_q) begin
      if (bit_end) begin
        tick_q <= '0;
        if (done) busy_q <= 1'b0;
        else begin
          ser_q  <= data_q[0];
          data_q <= {1'b1, data_q[PKT_W:1]};
          bit_q  <= bit_q + 1'b1;
        end
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign busy    = busy_q;
  assign ser_out = ser_q;

  // R9
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> ser_q);
  // R9
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !ser_q);
endmodule

// File: rtl/evt_pkt_reporter.sv
module evt_pkt_reporter
  import evrp_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 1000,
  parameter int unsigned BIT_TICKS    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ev_vsync,
  input  logic       ev_miss,
  input  logic       ev_miss_wr,
  input  logic       ev_miss_ifetch,
  input  logic       ev_addr_hit,
  input  logic       ev_vid_acc,
  output logic       ser_out
);
  logic [1:0]       ival_q;
  logic             vid_en_q, miss_en_q, rd_en_q;
  logic             ctrl_wr, test_req, expire, start, busy, done, restart;
  logic [PKT_W-1:0] pkt;

  assign ctrl_wr  = reg_wr && !reg_sel;
  assign test_req = ctrl_wr && reg_wdata[7];
  assign restart  = ctrl_wr || done;
  assign start    = !busy && (test_req || (expire && (pkt != '0)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ival_q <= 2'b00; vid_en_q <= 1'b0; miss_en_q <= 1'b0; rd_en_q <= 1'b0;
    end else if (ctrl_wr) begin
      ival_q    <= reg_wdata[1:0];
      vid_en_q  <= reg_wdata[2];
      miss_en_q <= reg_wdata[3];
      rd_en_q   <= reg_wdata[4];
    end
  end

  assign reg_rdata = reg_sel ? pkt : {3'b000, rd_en_q, miss_en_q, vid_en_q, ival_q};

  evrp_collector u_coll (
    .clk, .rst_n, .ev_vsync, .ev_miss, .ev_miss_wr, .ev_miss_ifetch,
    .ev_addr_hit, .ev_vid_acc, .vid_en(vid_en_q), .miss_en(miss_en_q),
    .rd_en(rd_en_q), .start, .busy, .done, .pkt
  );

  evrp_timer #(.TICKS_PER_MS(TICKS_PER_MS)) u_tmr (
    .clk, .rst_n, .sel(ival_q), .restart, .expire
  );

  evrp_shifter #(.BIT_TICKS(BIT_TICKS)) u_shf (
    .clk, .rst_n, .start, .pkt_in(pkt), .busy, .done, .ser_out
  );

  // R7
  no_empty_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && pkt == '0 && !test_req && !busy) |=> !busy);
  // R8
  test_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req && !busy) |=> (busy && !ser_out));
endmodule

// File: tb/sim_evt_pkt_reporter.sv
module sim_evt_pkt_reporter;
  localparam int TPM = 40;
  localparam int BT  = 3;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_sel = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic ev_vsync = 0, ev_miss = 0, ev_miss_wr = 0, ev_miss_ifetch = 0, ev_addr_hit = 0, ev_vid_acc = 0;
  logic ser_out;
  int errs = 0, checks = 0, cyc = 0;

  always #4 clk = ~clk;

  evt_pkt_reporter #(.TICKS_PER_MS(TPM), .BIT_TICKS(BT)) u0 (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    @(negedge clk); reg_wr = 1; reg_sel = 0; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  // ev bits: [5] vsync [4] miss [3] miss_wr [2] ifetch [1] addr_hit [0] vid
  task automatic pulse(input logic [5:0] e);
    @(negedge clk);
    {ev_vsync, ev_miss, ev_miss_wr, ev_miss_ifetch, ev_addr_hit, ev_vid_acc} = e;
    @(negedge clk);
    {ev_vsync, ev_miss, ev_miss_wr, ev_miss_ifetch, ev_addr_hit, ev_vid_acc} = '0;
  endtask

  function automatic logic [7:0] rd_pkt();
    return reg_rdata;
  endfunction

  task automatic read_reg(input logic s, output logic [7:0] v);
    reg_sel = s; #1; v = reg_rdata; reg_sel = 0;
  endtask

  // waits for a low line; returns at the falling edge of frame start (N0)
  task automatic wait_low(output int n);
    n = 0;
    while (ser_out && n < 5000) begin @(negedge clk); n++; end
  endtask

  // called at N0; returns at N0 + 1 + 9*BT
  task automatic grab(output logic [7:0] d, output logic st, output logic sp);
    @(negedge clk); st = ser_out;
    for (int k = 0; k < 8; k++) begin repeat (BT) @(negedge clk); d[k] = ser_out; end
    repeat (BT) @(negedge clk); sp = ser_out;
  endtask

  localparam logic [21:0] VEC [12] = '{
    {8'h1C, 6'b100000, 8'h80}, {8'h1C, 6'b011000, 8'h40}, {8'h1C, 6'b010000, 8'h40},
    {8'h0C, 6'b010000, 8'h00}, {8'h0C, 6'b011000, 8'h40}, {8'h1C, 6'b011100, 8'h00},
    {8'h10, 6'b010000, 8'h00}, {8'h1C, 6'b000010, 8'h02}, {8'h18, 6'b000001, 8'h00},
    {8'h04, 6'b000001, 8'h01}, {8'h00, 6'b100010, 8'h82}, {8'h1C, 6'b111011, 8'hC3}
  };

  initial begin
    logic [7:0] v, d;
    logic st, sp;
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ser_out", ser_out, 1);
    read_reg(0, v); chk("R1 ctrl", v, 8'h00);
    read_reg(1, v); chk("R1 pkt", v, 8'h00);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // vector table: gating, layout, repeat, test send, clear (R2 R3 R4 R5 R8 R9 R10)
    foreach (VEC[i]) begin
      write_ctrl(VEC[i][21:14]);
      pulse(VEC[i][13:8]);
      pulse(VEC[i][13:8]);
      read_reg(1, v); chk($sformatf("R2/R3/R4/R5 vec%0d pkt", i), v, VEC[i][7:0]);
      write_ctrl(VEC[i][21:14] | 8'h80);
      chk($sformatf("R8 vec%0d immediate start", i), ser_out, 0);
      grab(d, st, sp);
      chk($sformatf("R9 vec%0d frame", i), {st, d, sp}, {1'b0, VEC[i][7:0], 1'b1});
      repeat (BT + 2) @(negedge clk);
      read_reg(1, v); chk($sformatf("R10 vec%0d cleared", i), v, 8'h00);
    end

    // R3 accumulation of distinct events across separate pulses
    write_ctrl(8'h1C);
    pulse(6'b000010); pulse(6'b100000); pulse(6'b000010);
    read_reg(1, v); chk("R3 accumulate", v, 8'h82);
    write_ctrl(8'h9C); grab(d, st, sp); repeat (BT + 2) @(negedge clk);

    // R8 test bit reads back 0
    read_reg(0, v); chk("R8 test bit reads 0", v, 8'h1C);

    // R6 interval codes
    for (int c = 1; c < 4; c++) begin
      int mult;
      mult = (c == 1) ? 1 : (c == 2) ? 5 : 10;
      pulse(6'b100000);
      write_ctrl(8'h1C | 8'(c));
      n = 0;
      do begin @(negedge clk); n++; end while (ser_out && n < 2000);
      chk($sformatf("R6 code %0d start delay", c), n, mult * TPM);
      write_ctrl(8'h1C);
      repeat (10 * BT + 2) @(negedge clk);
    end
    // R6 code 00: no periodic send
    pulse(6'b100000);
    write_ctrl(8'h1C);
    n = 0;
    repeat (12 * TPM) begin @(negedge clk); if (!ser_out) n++; end
    chk("R6 code 00 silent", n, 0);
    write_ctrl(8'h9C); grab(d, st, sp); repeat (BT + 2) @(negedge clk);

    // R7 empty packet never sent on expiry
    write_ctrl(8'h1D);
    n = 0;
    repeat (3 * TPM + 5) begin @(negedge clk); if (!ser_out) n++; end
    chk("R7 empty not sent", n, 0);
    write_ctrl(8'h1C);

    // R10 event at the completing edge is kept
    pulse(6'b100000);
    write_ctrl(8'h9C);
    grab(d, st, sp);
    repeat (BT - 2) @(negedge clk);
    ev_addr_hit = 1; @(negedge clk); ev_addr_hit = 0;
    @(negedge clk);
    read_reg(1, v); chk("R10 event on done edge kept", v, 8'h02);
    write_ctrl(8'h9C); grab(d, st, sp);
    chk("R10 kept bit sent", d, 8'h02);
    repeat (BT + 2) @(negedge clk);

    // R11 events during shifting survive; R12 restart after frame
    write_ctrl(8'h1D);
    pulse(6'b100000);
    wait_low(n);
    pulse(6'b100010);
    repeat (10 * BT - 1) @(negedge clk);
    read_reg(1, v); chk("R11 in-flight events kept", v, 8'h82);
    n = 0;
    while (ser_out && n < 2000) begin @(negedge clk); n++; end
    chk("R12 next frame after restart", 10 * BT + 1 + n, 10 * BT + TPM);
    grab(d, st, sp);
    chk("R12 next frame data", {st, d, sp}, {1'b0, 8'h82, 1'b1});
    write_ctrl(8'h1C);
    repeat (BT + 2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule